// File: doc/BRIEF.md
# Rotating and Static Register File with Modulo Address Translation

This block is the local register file of one processing element in a coarse-grained reconfigurable array. Loop-carried values and loop-invariant values share one plain array of 16 entries of 32 bits. The array never moves its contents. Rotation is produced only by address arithmetic. A run-time boundary register splits the array. Physical entries below the boundary form the rotating region. Entries at or above it form the static region and are reached by direct index.

A rotating access names a window base, a window size from 1 to 8 and an offset. The block maps it to `base + ((offset + n mod size) mod size)`, where `n` is the number of iteration advances since the last loop start. Every window size has its own residue counter, so the iteration count never needs a divider and can never overflow.

The controller has three states:
- `ST_IDLE`: the reset state.
- `ST_PRELOAD`: entered from `ST_IDLE` by a preload write. In this state and in `ST_IDLE`, constants, pointers and initial values are written by physical index.
- `ST_RUN`: entered from either of the other states by `loop_start`. `loop_end` returns it to `ST_IDLE`.

Reads are combinational on two ports. The loop write port commits on the next rising edge.

Top module: `rotstat_rf`

## Requirements
- R1: A synchronous reset puts the controller in `ST_IDLE`, sets the boundary to 0 (all entries static), clears every residue counter and drives `err` low. Array contents are not reset.
- R2: A static access (`*_rot`=0) uses `*_base` as the physical index. The result does not depend on the iteration count.
- R3: A rotating access (`*_rot`=1) maps to physical index `base + ((off + n mod size) mod size)`, where `n` counts accepted advances since the last loop start.
- R4: Read data is combinational. A loop write takes effect at the next rising edge. A read of the entry being written in the same cycle returns the old value.
- R5: An enabled access is invalid if any of these holds: a static index below the boundary; a window with `base+size` above the boundary; size 0 or above 8; offset not below size. An invalid access raises `err` in the following cycle for exactly one cycle. An invalid read returns 0, and an invalid write is not committed.
- R6: A preload write reaches any physical index when the controller is in `ST_IDLE` or `ST_PRELOAD`. A preload write is ignored in `ST_RUN`.
- R7: `iter_adv` advances the iteration count only in `ST_RUN`. In other states it has no effect.
- R8: `loop_start` in any state clears the iteration count to 0 and enters `ST_RUN`. It takes priority over `iter_adv` in the same cycle.
- R9: Translation stays correct after any number of advances; 1000 advances are checked.
- R10: `cfg_we` loads the boundary only outside `ST_RUN`. Values above 16 are clamped to 16.
- R11: The loop write port is ignored outside `ST_RUN`.
- R12: The controller takes these transitions: `ST_IDLE`→`ST_PRELOAD` on `pre_we`, `ST_IDLE`/`ST_PRELOAD`→`ST_RUN` on `loop_start`, and `ST_RUN`→`ST_IDLE` on `loop_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load boundary |
| cfg_bound | input | 5 | Number of rotating entries (clamped to 16) |
| pre_we | input | 1 | Preload write strobe |
| pre_idx | input | 4 | Preload physical index |
| pre_data | input | 32 | Preload data |
| loop_start | input | 1 | Clear iteration count, enter run |
| loop_end | input | 1 | Leave run |
| iter_adv | input | 1 | Advance one iteration |
| rd0_en | input | 1 | Read port 0 enable (error checking) |
| rd0_rot | input | 1 | Port 0 rotating access select |
| rd0_base | input | 4 | Port 0 window base or static index |
| rd0_size | input | 4 | Port 0 window size |
| rd0_off | input | 3 | Port 0 offset in window |
| rd0_data | output | 32 | Port 0 read data |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_rot | input | 1 | Port 1 rotating access select |
| rd1_base | input | 4 | Port 1 window base or static index |
| rd1_size | input | 4 | Port 1 window size |
| rd1_off | input | 3 | Port 1 offset in window |
| rd1_data | output | 32 | Port 1 read data |
| wr_en | input | 1 | Loop write enable |
| wr_rot | input | 1 | Write rotating access select |
| wr_base | input | 4 | Write window base or static index |
| wr_size | input | 4 | Write window size |
| wr_off | input | 3 | Write offset in window |
| wr_data | input | 32 | Write data |
| err | output | 1 | One-cycle region violation flag |

## Verification
The bench sweeps every legal window over iterations 0 to 11 and again after 1000 advances. A translation that skips the residue reduction, or wraps across the whole rotating region, returns data from a neighbouring entry. It tries each class of region violation. A missing check would return stored data, or let a write corrupt an entry that a later rotating read exposes. It also issues strobes in the wrong state: preload and boundary writes during the loop, and advances and loop writes while idle. A controller that ignored its state would visibly change the mapping or the stored values.

// File: rtl/rotstat_rf_pkg.sv
package rotstat_rf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRELOAD = 2'd1,
        ST_RUN     = 2'd2
    } rf_state_e;
endpackage

// File: rtl/rotstat_rf_ctrl.sv
module rotstat_rf_ctrl
    import rotstat_rf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int MAXWIN = 8,
    parameter int BW     = $clog2(DEPTH) + 1,
    parameter int OW     = $clog2(MAXWIN)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [BW-1:0]                cfg_bound,
    input  logic                         pre_we,
    input  logic                         loop_start,
    input  logic                         loop_end,
    input  logic                         iter_adv,
    output rf_state_e                    state,
    output logic [BW-1:0]                bound,
    output logic [MAXWIN-1:0][OW-1:0]    res,
    output logic                         pre_take,
    output logic                         run
);
    rf_state_e     state_q, state_d;
    logic          cfg_take, adv_take;
    logic [BW-1:0] bound_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (loop_start)  state_d = ST_RUN;
                else if (pre_we) state_d = ST_PRELOAD;
            end
            ST_PRELOAD: if (loop_start) state_d = ST_RUN;
            ST_RUN:     if (loop_end && !loop_start) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        pre_take = 1'b0;
        cfg_take = 1'b0;
        adv_take = 1'b0;
        run      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRELOAD: begin
                pre_take = pre_we;
                cfg_take = cfg_we;
            end
            ST_RUN: begin
                run      = 1'b1;
                adv_take = iter_adv && !loop_start;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bound_q <= '0;
        else if (cfg_take)
            bound_q <= (cfg_bound > BW'(DEPTH)) ? BW'(DEPTH) : cfg_bound;
    end

    // one residue counter per window size g+1
    for (genvar g = 0; g < MAXWIN; g++) begin : g_res
        logic [OW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst || loop_start)
                r_q <= '0;
            else if (adv_take)
                r_q <= (r_q == OW'(g)) ? '0 : r_q + OW'(1);
        end
        assign res[g] = r_q;
    end

    assign state = state_q;
    assign bound = bound_q;
endmodule

// File: rtl/rotstat_rf_xlate.sv
module rotstat_rf_xlate #(
    parameter int DEPTH  = 16,
    parameter int MAXWIN = 8,
    parameter int IW     = $clog2(DEPTH),
    parameter int BW     = IW + 1,
    parameter int OW     = $clog2(MAXWIN),
    parameter int SW     = OW + 1
) (
    input  logic                      en,
    input  logic                      rot,
    input  logic [IW-1:0]             base,
    input  logic [SW-1:0]             size,
    input  logic [OW-1:0]             off,
    input  logic [BW-1:0]             bound,
    input  logic [MAXWIN-1:0][OW-1:0] res,
    output logic [IW-1:0]             phys,
    output logic                      bad
);
    logic          size_ok, off_ok, fit_ok;
    logic [OW-1:0] ridx, r;
    logic [SW-1:0] sum;

    always_comb begin
        size_ok = (size != '0) && (size <= SW'(MAXWIN));
        off_ok  = SW'(off) < size;
        fit_ok  = ((BW+1)'(base) + (BW+1)'(size)) <= (BW+1)'(bound);
        ridx    = OW'(size - SW'(1));
        r       = size_ok ? res[ridx] : '0;
        sum     = SW'(off) + SW'(r);
        if (sum >= size) sum = sum - size;
        if (rot) begin
            phys = base + IW'(sum);
            bad  = en && !(size_ok && off_ok && fit_ok);
        end else begin
            phys = base;
            bad  = en && (BW'(base) < bound);
        end
    end
endmodule

// File: rtl/rotstat_rf_store.sv
module rotstat_rf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [IW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][IW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/rotstat_rf.sv
module rotstat_rf
    import rotstat_rf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DW     = 32,
    parameter int MAXWIN = 8,
    parameter int IW     = $clog2(DEPTH),
    parameter int BW     = IW + 1,
    parameter int OW     = $clog2(MAXWIN),
    parameter int SW     = OW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [BW-1:0] cfg_bound,
    input  logic          pre_we,
    input  logic [IW-1:0] pre_idx,
    input  logic [DW-1:0] pre_data,
    input  logic          loop_start,
    input  logic          loop_end,
    input  logic          iter_adv,
    input  logic          rd0_en,
    input  logic          rd0_rot,
    input  logic [IW-1:0] rd0_base,
    input  logic [SW-1:0] rd0_size,
    input  logic [OW-1:0] rd0_off,
    output logic [DW-1:0] rd0_data,
    input  logic          rd1_en,
    input  logic          rd1_rot,
    input  logic [IW-1:0] rd1_base,
    input  logic [SW-1:0] rd1_size,
    input  logic [OW-1:0] rd1_off,
    output logic [DW-1:0] rd1_data,
    input  logic          wr_en,
    input  logic          wr_rot,
    input  logic [IW-1:0] wr_base,
    input  logic [SW-1:0] wr_size,
    input  logic [OW-1:0] wr_off,
    input  logic [DW-1:0] wr_data,
    output logic          err
);
    localparam int NRD = 2;

    rf_state_e                 state;
    logic [BW-1:0]             bound;
    logic [MAXWIN-1:0][OW-1:0] res;
    logic                      pre_take, run;

    logic [NRD-1:0]            rd_en, rd_rot, rd_bad;
    logic [NRD-1:0][IW-1:0]    rd_base, rd_phys;
    logic [NRD-1:0][SW-1:0]    rd_size;
    logic [NRD-1:0][OW-1:0]    rd_off;
    logic [NRD-1:0][DW-1:0]    rd_raw;

    logic [IW-1:0]             wr_phys, mem_waddr;
    logic [DW-1:0]             mem_wdata;
    logic                      wr_bad, wr_take, mem_we, err_q;

    rotstat_rf_ctrl #(.DEPTH(DEPTH), .MAXWIN(MAXWIN), .BW(BW), .OW(OW)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bound(cfg_bound),
        .pre_we(pre_we), .loop_start(loop_start), .loop_end(loop_end),
        .iter_adv(iter_adv), .state(state), .bound(bound), .res(res),
        .pre_take(pre_take), .run(run)
    );

    assign rd_en   = {rd1_en,   rd0_en};
    assign rd_rot  = {rd1_rot,  rd0_rot};
    assign rd_base = {rd1_base, rd0_base};
    assign rd_size = {rd1_size, rd0_size};
    assign rd_off  = {rd1_off,  rd0_off};

    for (genvar p = 0; p < NRD; p++) begin : g_rx
        rotstat_rf_xlate #(.DEPTH(DEPTH), .MAXWIN(MAXWIN), .IW(IW), .BW(BW),
                           .OW(OW), .SW(SW)) u_xl (
            .en(rd_en[p]), .rot(rd_rot[p]), .base(rd_base[p]), .size(rd_size[p]),
            .off(rd_off[p]), .bound(bound), .res(res),
            .phys(rd_phys[p]), .bad(rd_bad[p])
        );
    end

    rotstat_rf_xlate #(.DEPTH(DEPTH), .MAXWIN(MAXWIN), .IW(IW), .BW(BW),
                       .OW(OW), .SW(SW)) u_wx (
        .en(wr_en && run), .rot(wr_rot), .base(wr_base), .size(wr_size),
        .off(wr_off), .bound(bound), .res(res), .phys(wr_phys), .bad(wr_bad)
    );

    assign wr_take   = wr_en && run && !wr_bad;
    assign mem_we    = wr_take || pre_take;
    assign mem_waddr = run ? wr_phys : pre_idx;
    assign mem_wdata = run ? wr_data : pre_data;

    rotstat_rf_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD), .IW(IW)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_phys), .rdata(rd_raw)
    );

    assign rd0_data = rd_bad[0] ? '0 : rd_raw[0];
    assign rd1_data = rd_bad[1] ? '0 : rd_raw[1];

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= (|rd_bad) || wr_bad;
    end
    assign err = err_q;
endmodule

// File: rtl/rotstat_rf_chk.sv
module rotstat_rf_chk
    import rotstat_rf_pkg::*;
#(
    parameter int MAXWIN = 8,
    parameter int BW     = 5,
    parameter int OW     = 3
) (
    input logic                      clk,
    input logic                      rst,
    input rf_state_e                 state,
    input logic [BW-1:0]             bound,
    input logic [MAXWIN-1:0][OW-1:0] res,
    input logic                      mem_we,
    input logic                      wr_en,
    input logic                      wr_bad,
    input logic                      loop_start,
    input logic                      rd0_en,
    input logic                      rd1_en,
    input logic                      err
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_IDLE && bound == '0 && res == '0 && !err));

    // R5
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(rd0_en || rd1_en || wr_en));

    // R5
    bad_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        wr_bad |-> !mem_we);

    // R6
    run_pre_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !wr_en) |-> !mem_we);

    // R7
    idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && !loop_start) |=> $stable(res));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        loop_start |=> (res == '0 && state == ST_RUN));

    // R10
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> $stable(bound));

    for (genvar g = 0; g < MAXWIN; g++) begin : g_rc
        // R9
        res_range_chk: assert property (@(posedge clk) disable iff (rst)
            res[g] <= OW'(g));
    end
endmodule

bind rotstat_rf rotstat_rf_chk #(.MAXWIN(MAXWIN), .BW(BW), .OW(OW)) u_chk (
    .clk(clk), .rst(rst), .state(state), .bound(bound), .res(res),
    .mem_we(mem_we), .wr_en(wr_en), .wr_bad(wr_bad), .loop_start(loop_start),
    .rd0_en(rd0_en), .rd1_en(rd1_en), .err(err)
);

// File: tb/rotstat_rf_tb.sv
`timescale 1ns/1ps
module rotstat_rf_tb;
    logic        clk = 0, rst = 1;
    logic        cfg_we = 0;      logic [4:0] cfg_bound = 0;
    logic        pre_we = 0;      logic [3:0] pre_idx = 0;  logic [31:0] pre_data = 0;
    logic        loop_start = 0, loop_end = 0, iter_adv = 0;
    logic        rd0_en = 0, rd0_rot = 0; logic [3:0] rd0_base = 0, rd0_size = 0; logic [2:0] rd0_off = 0;
    logic        rd1_en = 0, rd1_rot = 0; logic [3:0] rd1_base = 0, rd1_size = 0; logic [2:0] rd1_off = 0;
    logic        wr_en = 0, wr_rot = 0;   logic [3:0] wr_base = 0, wr_size = 0;   logic [2:0] wr_off = 0;
    logic [31:0] wr_data = 0, rd0_data, rd1_data;
    logic        err;

    int checks = 0, errors = 0, n_it = 0;
    logic [31:0] model [16];

    always #2 clk = ~clk;

    rotstat_rf u_dut (.*);

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd0_set(logic rot, int b, int s, int o);
        rd0_en = 1; rd0_rot = rot; rd0_base = 4'(b); rd0_size = 4'(s); rd0_off = 3'(o);
    endtask

    function automatic logic [31:0] rot_exp(int b, int s, int o);
        return model[b + ((o + (n_it % s)) % s)];
    endfunction

    task automatic chk_rot(string req, int b, int s, int o);
        rd0_set(1, b, s, o); #0.1;
        chk(req, rd0_data, rot_exp(b, s, o));
        rd0_en = 0;
    endtask

    task automatic chk_static(string req, int i);
        rd1_en = 1; rd1_rot = 0; rd1_base = 4'(i); #0.1;
        chk(req, rd1_data, model[i]);
        rd1_en = 0;
    endtask

    task automatic sweep(string req);
        for (int s = 1; s <= 8; s++)
            for (int b = 0; b + s <= 8; b++)
                for (int o = 0; o < s; o++)
                    chk_rot(req, b, s, o);
        for (int i = 8; i < 16; i++) chk_static("R2 static direct", i);
    endtask

    task automatic adv(); iter_adv = 1; tick(); iter_adv = 0; n_it++; endtask

    task automatic preload(int i, logic [31:0] d);
        pre_we = 1; pre_idx = 4'(i); pre_data = d; tick(); pre_we = 0;
    endtask

    // bad access currently driven: check err pulse of one cycle
    task automatic err_pulse(string req);
        tick();
        chk({req, " err high"}, 32'(err), 32'd1);
        rd0_en = 0; rd1_en = 0; wr_en = 0;
        tick();
        chk({req, " err one cycle"}, 32'(err), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        chk("R1 err after reset", 32'(err), 0);
        rd1_en = 1; rd1_base = 0; tick(); rd1_en = 0;
        chk("R1 boundary zero, static ok", 32'(err), 0);
        rd0_set(1, 0, 1, 0); #0.1;
        chk("R1 rotating read with zero boundary returns 0", rd0_data, 0);
        err_pulse("R1 rotating window past zero boundary");

        // R10, R12, R6: configure and preload every entry
        cfg_we = 1; cfg_bound = 8; tick(); cfg_we = 0;
        for (int i = 0; i < 16; i++) begin
            model[i] = 32'hA500_0000 + 32'(i * 32'h111);
            preload(i, model[i]);
        end
        chk_static("R6 preload landed", 12);

        // R8, R3: start loop and sweep iterations 0..11
        loop_start = 1; tick(); loop_start = 0; n_it = 0;
        for (int n = 0; n < 12; n++) begin
            sweep("R3 rotating map");
            adv();
        end

        // R10 boundary write ignored while running
        cfg_we = 1; cfg_bound = 4; tick(); cfg_we = 0;
        rd1_en = 1; rd1_rot = 0; rd1_base = 6;
        err_pulse("R10 boundary held in run");

        // R6 preload ignored in run
        preload(10, 32'hDEAD_0010);
        chk_static("R6 preload ignored in run", 10);

        // R4 write then readback, old value in same cycle
        wr_en = 1; wr_rot = 1; wr_base = 4; wr_size = 4; wr_off = 1; wr_data = 32'h1234_5678;
        chk_rot("R4 same-cycle read old", 4, 4, 1);
        tick(); wr_en = 0;
        model[4 + ((1 + n_it % 4) % 4)] = 32'h1234_5678;
        chk_rot("R4 write visible next cycle", 4, 4, 1);
        wr_en = 1; wr_rot = 0; wr_base = 12; wr_data = 32'h0BAD_F00D; tick(); wr_en = 0;
        model[12] = 32'h0BAD_F00D;
        chk_static("R4 static write", 12);

        // R5 violations
        wr_en = 1; wr_rot = 0; wr_base = 2; wr_data = 32'hFFFF_0002;
        err_pulse("R5 static write into rotating region");
        chk_rot("R5 suppressed write left entry", 2, 1, 0);
        rd0_set(1, 6, 4, 0); #0.1;
        chk("R5 window past boundary data", rd0_data, 0);
        err_pulse("R5 window past boundary");
        rd0_set(1, 0, 3, 3); #0.1;
        chk("R5 offset not below size data", rd0_data, 0);
        err_pulse("R5 offset not below size");
        rd0_set(1, 0, 0, 0);
        err_pulse("R5 size zero");
        rd0_set(1, 0, 9, 0);
        err_pulse("R5 size above eight");
        wr_en = 1; wr_rot = 1; wr_base = 6; wr_size = 4; wr_off = 0; wr_data = 32'hFFFF_0006;
        err_pulse("R5 rotating write past boundary");
        chk_rot("R5 rotating bad write suppressed", 6, 2, 0);
        chk_rot("R5 rotating bad write suppressed", 6, 2, 1);

        // R12 leave run; R7 advance ignored in idle; R11 write ignored in idle
        loop_end = 1; tick(); loop_end = 0;
        adv(); n_it--; adv(); n_it--;
        for (int s = 1; s <= 8; s++) chk_rot("R7 advance ignored in idle", 0, s, 0);
        wr_en = 1; wr_rot = 0; wr_base = 13; wr_data = 32'h7777_7777; tick(); wr_en = 0;
        chk_static("R11 write ignored in idle", 13);
        model[9] = 32'h0000_0909; preload(9, model[9]);
        chk_static("R12 idle accepts preload again", 9);

        // R10 clamp
        cfg_we = 1; cfg_bound = 20; tick(); cfg_we = 0;
        rd1_en = 1; rd1_rot = 0; rd1_base = 15;
        err_pulse("R10 clamp to 16");
        cfg_we = 1; cfg_bound = 8; tick(); cfg_we = 0;

        // R8 restart clears count, priority over advance
        iter_adv = 1; loop_start = 1; tick(); iter_adv = 0; loop_start = 0; n_it = 0;
        for (int s = 1; s <= 8; s++) chk_rot("R8 restart clears count", 0, s, s - 1);

        // R9 long run
        for (int k = 0; k < 1000; k++) adv();
        sweep("R9 map after 1000 advances");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule